// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is a single output cell for a programmable sum-of-products array. It takes a parameterised group of product-term signals and ORs them into one sum. A flip-flop can capture the sum, or the cell can pass it straight through. A polarity stage then drives the pin value. A separate product term drives the pin enable. The cell also returns a feedback bit to the array.

The register has several control paths, in this priority order:
- a power-up clear and an asynchronous clear, both of which force it low;
- a one-edge recovery hold after either clear is released;
- a gated test preload that can force either level;
- a synchronous preset;
- the ordinary capture of the sum.

The array side instantiates one cell per output. Each cell can have its own term count. A two-bit mode input selects registered or combinational operation and true or inverted polarity.

Top module: `sop_out_cell`

## Requirements
- R1: `mode[1]` selects the data path: 0 takes the register, 1 takes the live sum. `mode[0]`=1 inverts the pin value. The resulting encodings are 00 registered true, 01 registered inverted, 10 combinational true and 11 combinational inverted.
- R2: The sum is the OR of all `NTERMS` product-term inputs, including the highest-numbered one. `NTERMS` must lie between 8 and 16, and elaboration rejects any other value.
- R3: While `arst` is high, the register is 0 at once, without waiting for a clock edge.
- R4: When `spreset` is high at a rising edge, the register becomes 1, provided no higher-priority control is active.
- R5: When `arst` and `spreset` are both high, the clear wins, and the register stays 0 for as long as `arst` is held.
- R6: On the first rising edge after a clear (`arst` or `por`) is released, the register keeps 0 and ignores preset, preload and sum.
- R7: While `por` is high, the register is 0. The pin then follows the polarity, so registered inverted mode drives 1.
- R8: When `pl_en` and `pl_req` are both high at a rising edge, the register loads `pl_val`, overriding both preset and sum.
- R9: When `pl_en` is low, a preload request has no effect, and the register takes preset or sum as usual.
- R10: `pin_oe` follows `pt_oe`. A 0 on `pin_oe` means the pin driver is high impedance.
- R11: In registered modes, `fb` is the true register value. In combinational modes, `fb` is `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| por | input | 1 | Power-up reset, active high, asynchronous clear |
| arst | input | 1 | Asynchronous clear, active high |
| mode | input | 2 | Output mode, encoded as in R1 |
| terms | input | NTERMS | Product-term inputs to the sum |
| pt_oe | input | 1 | Output-enable product term |
| spreset | input | 1 | Synchronous preset |
| pl_en | input | 1 | Preload permission, driven by the lock block |
| pl_req | input | 1 | Preload request |
| pl_val | input | 1 | Level to preload |
| pin_in | input | 1 | Level currently present on the pin |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin driver enable; 0 means high impedance |
| fb | output | 1 | Feedback to the array |

## Verification
The clocked properties assume that `arst` and `por` change only away from the rising edge. They also assume that once either is asserted, it is held across at least one edge, so a clear never comes and goes between two samples. The stimulus follows this rule: it changes every input just after a falling edge, and it holds each clear for whole cycles. The only check of the asynchronous clear that falls inside a cycle is taken directly at the pins, a short time after `arst` rises.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;
   localparam int MIN_TERMS = 8;
   localparam int MAX_TERMS = 16;

   typedef enum logic [1:0] {
      MODE_REG_HI = 2'b00,
      MODE_REG_LO = 2'b01,
      MODE_CMB_HI = 2'b10,
      MODE_CMB_LO = 2'b11
   } cell_mode_e;

   function automatic logic mode_bypass(input cell_mode_e m);
      return m[1];
   endfunction

   function automatic logic mode_invert(input cell_mode_e m);
      return m[0];
   endfunction
endpackage

// File: rtl/sop_term_sum.sv
module sop_term_sum #(
   parameter int NTERMS = 8,
   parameter int GROUP  = 4
) (
   input  logic [NTERMS-1:0] terms,
   output logic              sum
);
   localparam int NGRP = (NTERMS + GROUP - 1) / GROUP;

   generate
      if (GROUP >= NTERMS) begin : g_flat
         assign sum = |terms;
      end else begin : g_tree
         logic [NGRP-1:0] grp_or;
         for (genvar g = 0; g < NGRP; g++) begin : g_grp
            logic [GROUP-1:0] slice;
            for (genvar k = 0; k < GROUP; k++) begin : g_bit
               if (g * GROUP + k < NTERMS) begin : g_live
                  assign slice[k] = terms[g * GROUP + k];
               end else begin : g_pad
                  assign slice[k] = 1'b0;
               end
            end
            assign grp_or[g] = |slice;
         end
         assign sum = |grp_or;
      end
   endgenerate
endmodule

// File: rtl/sop_cell_reg.sv
module sop_cell_reg (
   input  logic clk,
   input  logic clr,
   input  logic d_sum,
   input  logic preset,
   input  logic pl_en,
   input  logic pl_req,
   input  logic pl_val,
   output logic q,
   output logic rec
);
   logic pl_take;
   logic d_next;

   assign pl_take = pl_en & pl_req;

   always_comb begin
      if (pl_take)      d_next = pl_val;
      else if (preset)  d_next = 1'b1;
      else              d_next = d_sum;
   end

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         q   <= 1'b0;
         rec <= 1'b1;
      end else if (rec) begin
         rec <= 1'b0;
      end else begin
         q   <= d_next;
      end
   end
endmodule

// File: rtl/sop_cell_outsel.sv
module sop_cell_outsel
   import sop_cell_pkg::*;
(
   input  cell_mode_e mode,
   input  logic       q,
   input  logic       sum,
   input  logic       pin_in,
   input  logic       pt_oe,
   output logic       pin_out,
   output logic       pin_oe,
   output logic       fb
);
   logic core;

   always_comb begin
      core    = mode_bypass(mode) ? sum : q;
      pin_out = core ^ mode_invert(mode);
      pin_oe  = pt_oe;
      fb      = mode_bypass(mode) ? pin_in : q;
   end
endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
   import sop_cell_pkg::*;
#(
   parameter int NTERMS = 8,
   parameter int GROUP  = 4
) (
   input  logic              clk,
   input  logic              por,
   input  logic              arst,
   input  logic [1:0]        mode,
   input  logic [NTERMS-1:0] terms,
   input  logic              pt_oe,
   input  logic              spreset,
   input  logic              pl_en,
   input  logic              pl_req,
   input  logic              pl_val,
   input  logic              pin_in,
   output logic              pin_out,
   output logic              pin_oe,
   output logic              fb
);
   generate
      if (NTERMS < MIN_TERMS || NTERMS > MAX_TERMS) begin : g_bad_terms
         $error("sop_out_cell: NTERMS out of range");
      end
      if (GROUP < 1) begin : g_bad_group
         $error("sop_out_cell: GROUP must be positive");
      end
   endgenerate

   logic       sum_w;
   logic       q_r;
   logic       rec_r;
   logic       clr_w;
   cell_mode_e mode_e;

   assign clr_w  = por | arst;
   assign mode_e = cell_mode_e'(mode);

   sop_term_sum #(.NTERMS(NTERMS), .GROUP(GROUP)) u_sum (
      .terms (terms),
      .sum   (sum_w)
   );

   sop_cell_reg u_reg (
      .clk    (clk),
      .clr    (clr_w),
      .d_sum  (sum_w),
      .preset (spreset),
      .pl_en  (pl_en),
      .pl_req (pl_req),
      .pl_val (pl_val),
      .q      (q_r),
      .rec    (rec_r)
   );

   sop_cell_outsel u_out (
      .mode    (mode_e),
      .q       (q_r),
      .sum     (sum_w),
      .pin_in  (pin_in),
      .pt_oe   (pt_oe),
      .pin_out (pin_out),
      .pin_oe  (pin_oe),
      .fb      (fb)
   );
endmodule

// File: rtl/sop_out_cell_chk.sv
module sop_out_cell_chk (
   input logic clk,
   input logic por,
   input logic arst,
   input logic spreset,
   input logic pl_en,
   input logic pl_req,
   input logic pl_val,
   input logic q,
   input logic rec,
   input logic sum
);
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (por)
      arst |-> !q); // R5

   AST_RECOVER_HOLD: assert property (@(posedge clk) disable iff (por || arst)
      ($fell(arst) || $fell(por)) |=> !q); // R6

   AST_PRESET_SETS: assert property (@(posedge clk) disable iff (por || arst)
      (!rec && spreset && !(pl_en && pl_req)) |=> q); // R4

   AST_PRELOAD_LOADS: assert property (@(posedge clk) disable iff (por || arst)
      (!rec && pl_en && pl_req) |=> (q == $past(pl_val))); // R8

   AST_PRELOAD_GATED: assert property (@(posedge clk) disable iff (por || arst)
      (!rec && !pl_en && !spreset) |=> (q == $past(sum))); // R9

   AST_POR_CLEARS: assert property (@(posedge clk)
      por |-> !q); // R7
endmodule

bind sop_out_cell sop_out_cell_chk u_chk (
   .clk     (clk),
   .por     (por),
   .arst    (arst),
   .spreset (spreset),
   .pl_en   (pl_en),
   .pl_req  (pl_req),
   .pl_val  (pl_val),
   .q       (q_r),
   .rec     (rec_r),
   .sum     (sum_w)
);

// File: tb/tb_sop_out_cell.sv
module tb_sop_out_cell;
   localparam int CLK_P  = 10;
   localparam int NT     = 10;
   localparam int WD_CYC = 5000;

   logic          clk = 1'b0;
   logic          por, arst, pt_oe, spreset, pl_en, pl_req, pl_val, pin_in;
   logic [1:0]    mode;
   logic [NT-1:0] terms;
   logic          pin_out, pin_oe, fb;

   int errors = 0;
   int checks = 0;

   typedef struct {
      logic  pin_out;
      logic  oe;
      logic  fb;
      string req;
   } exp_t;

   exp_t sb[$];
   logic mq   = 1'b0;
   logic mrec = 1'b1;

   always #(CLK_P/2) clk = ~clk;

   sop_out_cell #(.NTERMS(NT), .GROUP(4)) dut (
      .clk(clk), .por(por), .arst(arst), .mode(mode), .terms(terms),
      .pt_oe(pt_oe), .spreset(spreset), .pl_en(pl_en), .pl_req(pl_req),
      .pl_val(pl_val), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .fb(fb)
   );

   task automatic tick(input string req);
      exp_t e;
      if (por || arst) begin
         mq = 1'b0; mrec = 1'b1;
      end else if (mrec) begin
         mrec = 1'b0;
      end else if (pl_en && pl_req) begin
         mq = pl_val;
      end else if (spreset) begin
         mq = 1'b1;
      end else begin
         mq = |terms;
      end
      e.pin_out = (mode[1] ? (|terms) : mq) ^ mode[0];
      e.oe      = pt_oe;
      e.fb      = mode[1] ? pin_in : mq;
      e.req     = req;
      sb.push_back(e);
      @(negedge clk);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // monitor: compares each queued item a quarter period after the edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (pin_out !== e.pin_out || pin_oe !== e.oe || fb !== e.fb) begin
               errors++;
               $display("FAIL %s: pin_out/oe/fb actual=%b%b%b expected=%b%b%b",
                        e.req, pin_out, pin_oe, fb, e.pin_out, e.oe, e.fb);
            end
         end
      end
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      por = 1'b1; arst = 1'b0; mode = 2'b01; terms = '0; pt_oe = 1'b1;
      spreset = 1'b0; pl_en = 1'b0; pl_req = 1'b0; pl_val = 1'b0; pin_in = 1'b0;
      @(negedge clk);
      // R7: power-up clear, registered inverted mode drives 1
      tick("R7"); tick("R7");
      // R6: first edge after release ignores preset
      por = 1'b0; spreset = 1'b1; terms = '1;
      tick("R6");
      // R4: preset sets the register
      terms = '0;
      tick("R4");
      spreset = 1'b0;
      // R2: sum of various term patterns, registered true mode (R1)
      mode = 2'b00; terms = 10'b0000100000; tick("R2");
      terms = '0;                           tick("R2");
      terms = 10'b1000000000;               tick("R2");
      terms = 10'b0000000001;               tick("R1");
      // R11 / R1: combinational modes, feedback from pin
      mode = 2'b10; terms = 10'b0001000000; pin_in = 1'b1; tick("R11");
      mode = 2'b11; pin_in = 1'b0;                         tick("R1");
      terms = '0;                                          tick("R1");
      // R10: enable term low
      pt_oe = 1'b0; tick("R10");
      pt_oe = 1'b1; mode = 2'b00;
      // R8: preload overrides preset and sum
      pl_en = 1'b1; pl_req = 1'b1; pl_val = 1'b0; spreset = 1'b1; terms = '1;
      tick("R8");
      pl_val = 1'b1; spreset = 1'b0; terms = '0;
      tick("R8");
      // R9: preload without permission is ignored
      pl_en = 1'b0; pl_req = 1'b1; pl_val = 1'b1; terms = '0;
      tick("R9");
      pl_req = 1'b0;
      spreset = 1'b1; tick("R4");
      // R3: immediate asynchronous clear, with preset held (R5)
      arst = 1'b1;
      #1;
      checks++;
      if (pin_out !== 1'b0) begin
         errors++;
         $display("FAIL R3: pin_out actual=%b expected=0", pin_out);
      end
      tick("R5"); tick("R5");
      arst = 1'b0; tick("R6");
      tick("R4");
      spreset = 1'b0; terms = 10'b0100000000; tick("R2");
      @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R1: queue actual=%0d expected=0", sb.size());
      end
      summary();
      $finish;
   end
endmodule